// File: doc/BRIEF.md
# Ring Node Forward/Deliver/Discard Unit

This block makes the per-frame decisions for a node sitting in a redundant ring that has two ring ports, A and B, plus a local host port. Every ring frame appears as a single descriptor: the ring port it arrived on, its source and destination MAC, its ring tag sequence number, and a flag that marks it truncated. For each descriptor the unit decides whether the host gets a copy and whether the frame continues out of the opposite ring port. When neither applies, the frame is dropped. The decision is based on the node's own address, the group bit of the destination, and a small seen-frame table. The table is keyed on (source MAC, sequence number) and holds a "delivered" bit plus one "sent" bit for each egress port.

Locally injected frames are stamped with the node's address and a running sequence number. A copy goes to each ring port. A small state machine tracks which copies are still owed. On any egress port, a forwarded ring frame always beats a local copy in the same cycle. Each decision registers once, so it appears on the outputs in the cycle after the descriptor is presented. This lets a byte-streaming path begin sending before the frame has finished arriving.

The injection machine has four states. INJ_IDLE accepts a host frame and goes to INJ_BOTH. From INJ_BOTH the machine goes back to INJ_IDLE if both ports were free. It goes to INJ_WAIT_B if only port A was free, and to INJ_WAIT_A if only port B was free. It stays in INJ_BOTH if both ports were busy. INJ_WAIT_A returns to INJ_IDLE once port A is free, and INJ_WAIT_B returns to INJ_IDLE once port B is free.

Top module: `hsr_ring_node`

## Requirements
- R1: After reset, host_rx_valid, ega_valid and egb_valid are low and host_tx_ready is high.
- R2: A descriptor with rx_trunc high produces no host delivery and no forward, and it leaves the table unchanged. A later intact copy with the same key is therefore treated as new.
- R3: A descriptor whose rx_src equals node_mac is neither delivered nor forwarded.
- R4: A unicast descriptor whose rx_dst equals node_mac is delivered on its first copy and is never forwarded.
- R5: A descriptor whose destination group bit is set is delivered on its first copy and is also forwarded. The group bit is bit MAC_W-8, which is bit 40 for 48-bit addresses and is the least significant bit of the top octet.
- R6: A unicast descriptor addressed to another node is forwarded and not delivered.
- R7: For a given (source, sequence) key, only the first accepted copy reaches the host, whichever ring port the copies arrive on.
- R8: A given key is sent out of a given egress port at most once. A frame from port 0 (A) goes out of port 1 (B), and the reverse holds as well.
- R9: A decision appears on host_rx_* and on the egress outputs in the clock cycle after rx_valid. A forwarded frame keeps its source, destination and sequence, and its egress local flag is low.
- R10: A host frame is accepted on a cycle where host_tx_valid and host_tx_ready are both high. From the next cycle, a copy with source node_mac is offered on each ring port, and host_tx_ready stays low until both copies have been offered.
- R11: If a forwarded frame and a pending local copy target the same egress port in the same cycle, the forwarded frame is offered and the local copy waits for the next free cycle.
- R12: Injected frames take sequence numbers 0, 1, 2 and so on after reset. The number rises by one per accepted frame and wraps from 2^SEQ_W-1 to 0.
- R13: The table holds DEPTH keys and replaces entries in round-robin order. After DEPTH newer keys have been allocated, an old key is forgotten and its next copy is delivered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_mac | input | MAC_W | This node's unicast address |
| rx_valid | input | 1 | Ring descriptor present |
| rx_port | input | 1 | Arrival port, 0 = A, 1 = B |
| rx_src | input | MAC_W | Frame source address |
| rx_dst | input | MAC_W | Frame destination address |
| rx_seq | input | SEQ_W | Ring tag sequence number |
| rx_trunc | input | 1 | Frame is truncated |
| host_tx_valid | input | 1 | Host frame to inject |
| host_tx_dst | input | MAC_W | Destination of host frame |
| host_tx_ready | output | 1 | Injector can accept a frame |
| host_rx_valid | output | 1 | Deliver to host |
| host_rx_port | output | 1 | Port the delivered copy came from |
| host_rx_src | output | MAC_W | Delivered source |
| host_rx_dst | output | MAC_W | Delivered destination |
| host_rx_seq | output | SEQ_W | Delivered sequence |
| ega_valid | output | 1 | Port A egress offer |
| ega_local | output | 1 | Port A offer is a local copy |
| ega_src | output | MAC_W | Port A offered source |
| ega_dst | output | MAC_W | Port A offered destination |
| ega_seq | output | SEQ_W | Port A offered sequence |
| egb_valid | output | 1 | Port B egress offer |
| egb_local | output | 1 | Port B offer is a local copy |
| egb_src | output | MAC_W | Port B offered source |
| egb_dst | output | MAC_W | Port B offered destination |
| egb_seq | output | SEQ_W | Port B offered sequence |

## Verification
Directed sequences cover the cases that a single rule separates:
- a truncated copy followed by a good copy, which shows that truncation does not touch the table;
- a copy that loops back on its own port, which tells per-port forwarding apart from a single global forwarded bit;
- a frame forwarded in the same cycle as a host injection, which exposes the egress priority;
- one key refreshed after DEPTH newer keys, which shows the replacement order.

A long run of host injections crosses the sequence wrap. Seeded random descriptors draw from a key pool larger than the table, with mixed destination classes, ports, own-source and truncated frames. This sets the delivered and sent bits against eviction in many orders, and each step is compared with a bench model of the rules.

// File: rtl/hsr_ring_pkg.sv
package hsr_ring_pkg;
    typedef enum logic [1:0] {
        INJ_IDLE,
        INJ_BOTH,
        INJ_WAIT_A,
        INJ_WAIT_B
    } inj_state_t;

    localparam int RING_PORTS = 2;
endpackage

// File: rtl/hsr_dup_table.sv
module hsr_dup_table #(
    parameter int DEPTH = 8,
    parameter int MAC_W = 48,
    parameter int SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MAC_W-1:0] lk_src,
    input  logic [SEQ_W-1:0] lk_seq,
    output logic             hit,
    output logic             hit_dl,
    output logic [1:0]       hit_fw,
    input  logic             upd_en,
    input  logic             upd_dl,
    input  logic [1:0]       upd_fw
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] ent_v;
    logic [DEPTH-1:0] ent_dl;
    logic [MAC_W-1:0] ent_src [DEPTH];
    logic [SEQ_W-1:0] ent_seq [DEPTH];
    logic [1:0]       ent_fw  [DEPTH];
    logic [DEPTH-1:0] match;
    logic [IW-1:0]    hit_idx;
    logic [IW-1:0]    rr_ptr;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = ent_v[g] && (ent_src[g] == lk_src) && (ent_seq[g] == lk_seq);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) hit_idx = IW'(i);
        end
        hit    = |match;
        hit_dl = hit & ent_dl[hit_idx];
        hit_fw = hit ? ent_fw[hit_idx] : 2'b00;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_v  <= '0;
            ent_dl <= '0;
            rr_ptr <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                ent_fw[i]  <= 2'b00;
                ent_src[i] <= '0;
                ent_seq[i] <= '0;
            end
        end else if (upd_en) begin
            if (hit) begin
                ent_dl[hit_idx] <= ent_dl[hit_idx] | upd_dl;
                ent_fw[hit_idx] <= ent_fw[hit_idx] | upd_fw;
            end else begin
                ent_v[rr_ptr]   <= 1'b1;
                ent_src[rr_ptr] <= lk_src;
                ent_seq[rr_ptr] <= lk_seq;
                ent_dl[rr_ptr]  <= upd_dl;
                ent_fw[rr_ptr]  <= upd_fw;
                rr_ptr          <= (rr_ptr == IW'(DEPTH - 1)) ? '0 : rr_ptr + 1'b1;
            end
        end
    end

    // Keys are only allocated on a miss, so at most one entry may match.
    assert_unique_key_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/hsr_inject_fsm.sv
module hsr_inject_fsm
    import hsr_ring_pkg::*;
#(
    parameter int MAC_W = 48,
    parameter int SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_valid,
    input  logic [MAC_W-1:0] tx_dst,
    input  logic [1:0]       ring_busy,
    output logic             tx_ready,
    output logic [1:0]       pend,
    output logic [MAC_W-1:0] loc_dst,
    output logic [SEQ_W-1:0] loc_seq
);
    inj_state_t state, state_nx;
    logic [SEQ_W-1:0] seq_ctr;
    logic             take;
    logic [1:0]       sent;

    assign take = tx_valid && tx_ready;
    assign sent = pend & ~ring_busy;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= INJ_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            INJ_IDLE:   if (tx_valid) state_nx = INJ_BOTH;
            INJ_BOTH: begin
                unique case (sent)
                    2'b11:   state_nx = INJ_IDLE;
                    2'b01:   state_nx = INJ_WAIT_B;
                    2'b10:   state_nx = INJ_WAIT_A;
                    default: state_nx = INJ_BOTH;
                endcase
            end
            INJ_WAIT_A: if (sent[0]) state_nx = INJ_IDLE;
            INJ_WAIT_B: if (sent[1]) state_nx = INJ_IDLE;
            default:    state_nx = INJ_IDLE;
        endcase
    end

    always_comb begin
        tx_ready = 1'b0;
        pend     = 2'b00;
        unique case (state)
            INJ_IDLE:   tx_ready = 1'b1;
            INJ_BOTH:   pend = 2'b11;
            INJ_WAIT_A: pend = 2'b01;
            INJ_WAIT_B: pend = 2'b10;
            default:    pend = 2'b00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_ctr <= '0;
            loc_seq <= '0;
            loc_dst <= '0;
        end else if (take) begin
            seq_ctr <= seq_ctr + 1'b1;
            loc_seq <= seq_ctr;
            loc_dst <= tx_dst;
        end
    end

    assert_seq_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> seq_ctr == SEQ_W'($past(seq_ctr) + 1'b1));
    assert_ready_owes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !tx_ready && pend == 2'b11);
    assert_ring_first_a_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[0] && ring_busy[0]) |=> pend[0]);
    assert_ring_first_b_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[1] && ring_busy[1]) |=> pend[1]);
endmodule

// File: rtl/hsr_egress_sel.sv
module hsr_egress_sel #(
    parameter int MAC_W = 48,
    parameter int SEQ_W = 16
) (
    input  logic             fwd_v,
    input  logic [MAC_W-1:0] fwd_src,
    input  logic [MAC_W-1:0] fwd_dst,
    input  logic [SEQ_W-1:0] fwd_seq,
    input  logic             loc_pend,
    input  logic [MAC_W-1:0] loc_src,
    input  logic [MAC_W-1:0] loc_dst,
    input  logic [SEQ_W-1:0] loc_seq,
    output logic             out_v,
    output logic             out_local,
    output logic [MAC_W-1:0] out_src,
    output logic [MAC_W-1:0] out_dst,
    output logic [SEQ_W-1:0] out_seq
);
    always_comb begin
        out_v     = fwd_v | loc_pend;
        out_local = loc_pend & ~fwd_v;
        out_src   = fwd_v ? fwd_src : loc_src;
        out_dst   = fwd_v ? fwd_dst : loc_dst;
        out_seq   = fwd_v ? fwd_seq : loc_seq;
    end
endmodule

// File: rtl/hsr_ring_node.sv
module hsr_ring_node
    import hsr_ring_pkg::*;
#(
    parameter int MAC_W = 48,
    parameter int SEQ_W = 16,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MAC_W-1:0] node_mac,
    input  logic             rx_valid,
    input  logic             rx_port,
    input  logic [MAC_W-1:0] rx_src,
    input  logic [MAC_W-1:0] rx_dst,
    input  logic [SEQ_W-1:0] rx_seq,
    input  logic             rx_trunc,
    input  logic             host_tx_valid,
    input  logic [MAC_W-1:0] host_tx_dst,
    output logic             host_tx_ready,
    output logic             host_rx_valid,
    output logic             host_rx_port,
    output logic [MAC_W-1:0] host_rx_src,
    output logic [MAC_W-1:0] host_rx_dst,
    output logic [SEQ_W-1:0] host_rx_seq,
    output logic             ega_valid,
    output logic             ega_local,
    output logic [MAC_W-1:0] ega_src,
    output logic [MAC_W-1:0] ega_dst,
    output logic [SEQ_W-1:0] ega_seq,
    output logic             egb_valid,
    output logic             egb_local,
    output logic [MAC_W-1:0] egb_src,
    output logic [MAC_W-1:0] egb_dst,
    output logic [SEQ_W-1:0] egb_seq
);
    localparam int GRP_BIT = MAC_W - 8;

    logic       hit, hit_dl;
    logic [1:0] hit_fw;
    logic       accept, to_me, grp, do_dl, do_fwd;
    logic [1:0] out_sel;

    logic [1:0]       fwd_v;
    logic [MAC_W-1:0] fwd_src, fwd_dst;
    logic [SEQ_W-1:0] fwd_seq;

    logic [1:0]       pend;
    logic [MAC_W-1:0] loc_dst;
    logic [SEQ_W-1:0] loc_seq;

    logic [1:0]       eg_v, eg_loc;
    logic [MAC_W-1:0] eg_src [RING_PORTS];
    logic [MAC_W-1:0] eg_dst [RING_PORTS];
    logic [SEQ_W-1:0] eg_seq [RING_PORTS];

    hsr_dup_table #(.DEPTH(DEPTH), .MAC_W(MAC_W), .SEQ_W(SEQ_W)) u_table (
        .clk(clk), .rst_n(rst_n), .lk_src(rx_src), .lk_seq(rx_seq),
        .hit(hit), .hit_dl(hit_dl), .hit_fw(hit_fw),
        .upd_en(accept), .upd_dl(do_dl), .upd_fw(do_fwd ? out_sel : 2'b00)
    );

    always_comb begin
        accept  = rx_valid && !rx_trunc && (rx_src != node_mac);
        to_me   = (rx_dst == node_mac);
        grp     = rx_dst[GRP_BIT];
        out_sel = rx_port ? 2'b01 : 2'b10;
        do_dl   = accept && (to_me || grp) && !hit_dl;
        do_fwd  = accept && !to_me && ((hit_fw & out_sel) == 2'b00);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rx_valid <= 1'b0;
            host_rx_port  <= 1'b0;
            host_rx_src   <= '0;
            host_rx_dst   <= '0;
            host_rx_seq   <= '0;
            fwd_v         <= 2'b00;
            fwd_src       <= '0;
            fwd_dst       <= '0;
            fwd_seq       <= '0;
        end else begin
            host_rx_valid <= do_dl;
            fwd_v         <= do_fwd ? out_sel : 2'b00;
            if (accept) begin
                host_rx_port <= rx_port;
                host_rx_src  <= rx_src;
                host_rx_dst  <= rx_dst;
                host_rx_seq  <= rx_seq;
                fwd_src      <= rx_src;
                fwd_dst      <= rx_dst;
                fwd_seq      <= rx_seq;
            end
        end
    end

    hsr_inject_fsm #(.MAC_W(MAC_W), .SEQ_W(SEQ_W)) u_inject (
        .clk(clk), .rst_n(rst_n), .tx_valid(host_tx_valid), .tx_dst(host_tx_dst),
        .ring_busy(fwd_v), .tx_ready(host_tx_ready), .pend(pend),
        .loc_dst(loc_dst), .loc_seq(loc_seq)
    );

    for (genvar p = 0; p < RING_PORTS; p++) begin : g_egress
        hsr_egress_sel #(.MAC_W(MAC_W), .SEQ_W(SEQ_W)) u_sel (
            .fwd_v(fwd_v[p]), .fwd_src(fwd_src), .fwd_dst(fwd_dst), .fwd_seq(fwd_seq),
            .loc_pend(pend[p]), .loc_src(node_mac), .loc_dst(loc_dst), .loc_seq(loc_seq),
            .out_v(eg_v[p]), .out_local(eg_loc[p]),
            .out_src(eg_src[p]), .out_dst(eg_dst[p]), .out_seq(eg_seq[p])
        );
    end

    assign ega_valid = eg_v[0];
    assign ega_local = eg_loc[0];
    assign ega_src   = eg_src[0];
    assign ega_dst   = eg_dst[0];
    assign ega_seq   = eg_seq[0];
    assign egb_valid = eg_v[1];
    assign egb_local = eg_loc[1];
    assign egb_src   = eg_src[1];
    assign egb_dst   = eg_dst[1];
    assign egb_seq   = eg_seq[1];

    assert_trunc_dropped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_trunc) |=> !host_rx_valid && fwd_v == 2'b00);
    assert_own_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_src == node_mac) |=> !host_rx_valid && fwd_v == 2'b00);
    assert_sole_dest_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_dst == node_mac) |=> fwd_v == 2'b00);
    assert_opposite_port_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> (fwd_v & (2'b01 << $past(rx_port))) == 2'b00);
    assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> !host_rx_valid && fwd_v == 2'b00);
endmodule

// File: tb/sim_hsr_ring_node.sv
module sim_hsr_ring_node;
    localparam int CLK_PERIOD = 10;
    localparam int MW = 48;
    localparam int SW = 8;
    localparam int TD = 8;
    localparam int WD_LIMIT = 150000;
    localparam logic [MW-1:0] NODE  = 48'h02_00_00_00_00_AA;
    localparam logic [MW-1:0] GRP   = 48'h01_00_5E_00_00_01;
    localparam logic [MW-1:0] OTHER = 48'h02_00_00_00_00_BB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [MW-1:0] node_mac = NODE;
    logic rx_valid = 1'b0, rx_port = 1'b0, rx_trunc = 1'b0;
    logic [MW-1:0] rx_src = '0, rx_dst = '0;
    logic [SW-1:0] rx_seq = '0;
    logic host_tx_valid = 1'b0;
    logic [MW-1:0] host_tx_dst = '0;
    logic host_tx_ready, host_rx_valid, host_rx_port;
    logic [MW-1:0] host_rx_src, host_rx_dst;
    logic [SW-1:0] host_rx_seq;
    logic ega_valid, ega_local, egb_valid, egb_local;
    logic [MW-1:0] ega_src, ega_dst, egb_src, egb_dst;
    logic [SW-1:0] ega_seq, egb_seq;

    int n_tests = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [SW-1:0] exp_seq = '0;

    logic          mv [TD];
    logic [MW-1:0] ms [TD];
    logic [SW-1:0] mq [TD];
    logic          md [TD];
    logic [1:0]    mf [TD];
    int            mptr = 0;

    hsr_ring_node #(.MAC_W(MW), .SEQ_W(SW), .DEPTH(TD)) u0 (
        .clk(clk), .rst_n(rst_n), .node_mac(node_mac),
        .rx_valid(rx_valid), .rx_port(rx_port), .rx_src(rx_src), .rx_dst(rx_dst),
        .rx_seq(rx_seq), .rx_trunc(rx_trunc),
        .host_tx_valid(host_tx_valid), .host_tx_dst(host_tx_dst), .host_tx_ready(host_tx_ready),
        .host_rx_valid(host_rx_valid), .host_rx_port(host_rx_port), .host_rx_src(host_rx_src),
        .host_rx_dst(host_rx_dst), .host_rx_seq(host_rx_seq),
        .ega_valid(ega_valid), .ega_local(ega_local), .ega_src(ega_src), .ega_dst(ega_dst),
        .ega_seq(ega_seq),
        .egb_valid(egb_valid), .egb_local(egb_local), .egb_src(egb_src), .egb_dst(egb_dst),
        .egb_seq(egb_seq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD_LIMIT) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Rule model: classification, first-copy delivery, per-port sending, round-robin table.
    task automatic model_step(input logic port, input logic [MW-1:0] src, input logic [MW-1:0] dst,
                              input logic [SW-1:0] seq, input logic trunc,
                              output logic ed, output logic ef);
        logic cls, tome, grp, hit;
        int h;
        logic [1:0] q;
        cls  = !trunc && (src != NODE);
        tome = (dst == NODE);
        grp  = dst[40];
        hit  = 1'b0;
        h    = 0;
        for (int i = 0; i < TD; i++) begin
            if (mv[i] && ms[i] == src && mq[i] == seq) begin
                hit = 1'b1;
                h = i;
            end
        end
        q  = port ? 2'b01 : 2'b10;
        ed = cls && (tome || grp) && !(hit && md[h]);
        ef = cls && !tome && !(hit && ((mf[h] & q) != 2'b00));
        if (cls) begin
            if (hit) begin
                md[h] = md[h] | ed;
                mf[h] = mf[h] | (ef ? q : 2'b00);
            end else begin
                mv[mptr] = 1'b1;
                ms[mptr] = src;
                mq[mptr] = seq;
                md[mptr] = ed;
                mf[mptr] = ef ? q : 2'b00;
                mptr = (mptr + 1) % TD;
            end
        end
    endtask

    task automatic ring_step(input string req, input logic port, input logic [MW-1:0] src,
                             input logic [MW-1:0] dst, input logic [SW-1:0] seq,
                             input logic trunc);
        logic ed, ef;
        model_step(port, src, dst, seq, trunc, ed, ef);
        @(negedge clk);
        rx_valid = 1'b1; rx_port = port; rx_src = src; rx_dst = dst; rx_seq = seq;
        rx_trunc = trunc;
        @(posedge clk);
        #1;
        chk(req, "host_rx_valid", 64'(host_rx_valid), 64'(ed));
        if (ed) begin
            chk(req, "host_rx_src", 64'(host_rx_src), 64'(src));
            chk(req, "host_rx_seq", 64'(host_rx_seq), 64'(seq));
            chk(req, "host_rx_port", 64'(host_rx_port), 64'(port));
        end
        chk(req, "ega_valid", 64'(ega_valid), 64'(ef && port == 1'b1));
        chk(req, "egb_valid", 64'(egb_valid), 64'(ef && port == 1'b0));
        if (ef) begin
            chk(req, "eg_local", 64'(port ? ega_local : egb_local), 64'(0));
            chk(req, "eg_seq", 64'(port ? ega_seq : egb_seq), 64'(seq));
            chk(req, "eg_src", 64'(port ? ega_src : egb_src), 64'(src));
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_trunc = 1'b0;
    endtask

    task automatic inject_one(input string req, input logic [MW-1:0] dst);
        @(negedge clk);
        chk(req, "host_tx_ready before", 64'(host_tx_ready), 64'(1));
        host_tx_valid = 1'b1; host_tx_dst = dst;
        @(posedge clk);
        #1;
        chk(req, "ega local copy", {62'd0, ega_valid, ega_local}, 64'h3);
        chk(req, "egb local copy", {62'd0, egb_valid, egb_local}, 64'h3);
        chk(req, "local seq", 64'(ega_seq), 64'(exp_seq));
        chk(req, "local src/dst", {15'd0, ega_src == NODE, egb_dst}, {15'd0, 1'b1, dst});
        chk(req, "host_tx_ready busy", 64'(host_tx_ready), 64'(0));
        exp_seq = exp_seq + 1'b1;
        @(negedge clk);
        host_tx_valid = 1'b0;
        @(posedge clk);
        #1;
        chk(req, "ready after both sent", 64'(host_tx_ready), 64'(1));
    endtask

    initial begin
        logic ed, ef;
        for (int i = 0; i < TD; i++) begin
            mv[i] = 1'b0; ms[i] = '0; mq[i] = '0; md[i] = 1'b0; mf[i] = 2'b00;
        end
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "host_rx_valid", 64'(host_rx_valid), 64'(0));
        chk("R1", "eg valid", {62'd0, ega_valid, egb_valid}, 64'(0));
        chk("R1", "host_tx_ready", 64'(host_tx_ready), 64'(1));
        @(negedge clk);
        rst_n = 1'b1;

        // R4: unicast to this node: delivered, not forwarded; R7 twin not delivered
        ring_step("R4", 1'b0, 48'h02_00_00_00_01_01, NODE, 8'd1, 1'b0);
        ring_step("R7", 1'b1, 48'h02_00_00_00_01_01, NODE, 8'd1, 1'b0);
        // R6: unicast to another node: forwarded only
        ring_step("R6", 1'b0, 48'h02_00_00_00_01_02, OTHER, 8'd2, 1'b0);
        // R3: own frame coming back
        ring_step("R3", 1'b1, NODE, GRP, 8'd3, 1'b0);
        // R2: truncated copy first, then intact copy still delivered and forwarded
        ring_step("R2", 1'b0, 48'h02_00_00_00_01_03, GRP, 8'd4, 1'b1);
        ring_step("R2", 1'b1, 48'h02_00_00_00_01_03, GRP, 8'd4, 1'b0);
        chk("R2", "model deliver after trunc", 64'(md[mptr == 0 ? TD - 1 : mptr - 1]), 64'(1));
        // R5 / R8: group frame, twin on other port, loop-back on first port
        ring_step("R5", 1'b0, 48'h02_00_00_00_01_04, GRP, 8'd5, 1'b0);
        ring_step("R8", 1'b1, 48'h02_00_00_00_01_04, GRP, 8'd5, 1'b0);
        ring_step("R8", 1'b0, 48'h02_00_00_00_01_04, GRP, 8'd5, 1'b0);
        // R9: idle cycle after a decision shows nothing
        @(posedge clk);
        #1;
        chk("R9", "idle outputs", {61'd0, host_rx_valid, ega_valid, egb_valid}, 64'(0));

        // R13: key K, then TD newer keys, then K again is delivered again
        ring_step("R13", 1'b0, 48'h02_00_00_00_02_00, GRP, 8'd9, 1'b0);
        for (int k = 0; k < TD; k++)
            ring_step("R13", 1'b0, 48'h02_00_00_00_03_00, GRP, SW'(k + 16), 1'b0);
        ring_step("R13", 1'b1, 48'h02_00_00_00_02_00, GRP, 8'd9, 1'b0);
        chk("R13", "evicted key delivered again", 64'(host_rx_valid), 64'(1));

        // R10/R12: first injection carries seq 0
        inject_one("R10", GRP);
        chk("R12", "seq after first", 64'(exp_seq), 64'(1));

        // R11: forwarded frame and local injection in the same cycle
        model_step(1'b0, 48'h02_00_00_00_04_00, OTHER, 8'd7, 1'b0, ed, ef);
        @(negedge clk);
        host_tx_valid = 1'b1; host_tx_dst = OTHER;
        rx_valid = 1'b1; rx_port = 1'b0; rx_src = 48'h02_00_00_00_04_00; rx_dst = OTHER;
        rx_seq = 8'd7; rx_trunc = 1'b0;
        @(posedge clk);
        #1;
        chk("R11", "egb forward wins", {62'd0, egb_valid, egb_local}, 64'h2);
        chk("R11", "egb forward seq", 64'(egb_seq), 64'(7));
        chk("R11", "ega local", {62'd0, ega_valid, ega_local}, 64'h3);
        chk("R11", "ega local seq", 64'(ega_seq), 64'(exp_seq));
        @(negedge clk);
        host_tx_valid = 1'b0; rx_valid = 1'b0;
        @(posedge clk);
        #1;
        chk("R11", "egb local next", {62'd0, egb_valid, egb_local}, 64'h3);
        chk("R11", "egb local seq", 64'(egb_seq), 64'(exp_seq));
        chk("R11", "ega quiet", 64'(ega_valid), 64'(0));
        chk("R10", "ready low while owed", 64'(host_tx_ready), 64'(0));
        exp_seq = exp_seq + 1'b1;
        @(posedge clk);
        #1;
        chk("R10", "ready after both", 64'(host_tx_ready), 64'(1));

        // R12: run through the wrap of the sequence counter
        for (int k = 0; k < 260; k++) begin
            if (exp_seq == '0) chk("R12", "wrap reached", 64'(k > 0), 64'(1));
            inject_one("R12", OTHER);
        end

        // Seeded random ring traffic against the rule model
        void'($urandom(32'd20240611));
        for (int k = 0; k < 500; k++) begin
            logic [MW-1:0] s, d;
            logic t, p;
            int r;
            r = int'($urandom % 16);
            s = (r == 0) ? NODE : (48'h02_00_00_00_05_00 | MW'($urandom % 3));
            r = int'($urandom % 3);
            d = (r == 0) ? NODE : (r == 1) ? GRP : OTHER;
            t = ($urandom % 16) == 0;
            p = 1'($urandom % 2);
            ring_step("R7", p, s, d, SW'($urandom % 4), t);
        end

        repeat (2) @(posedge clk);
        summary();
        $finish;
    end
endmodule